// File: doc/BRIEF.md
# SDRAM Configuration and Power-Mode Controller

This block is the programmable front end of an SDRAM controller. It owns two registers: a configuration register that holds the device geometry, the CAS latency and the power-mode request bits, and a refresh-rate register. Both take 32-bit writes with per-byte strobes. From these registers it decides when the downstream command sequencer must re-run SDRAM initialization. It also tracks the refresh interval and steps the controller through its normal, power-down, power-down-with-refresh and self-refresh modes.

Every action is sent to the command sequencer as a single-cycle request pulse. A new mode transition starts only after the sequencer acknowledges the previous one. The decoded geometry and latency fields are driven as steady outputs, for the address mapper and for the mode-register load during initialization.

Top module: `sdram_cfg_ctrl`

## Requirements
- R1: During reset all request pulses are low, `cas_lat_o` is 3, `bank_cnt_o` is 2 and `page_sel_o` is 0. On the first clock edge after reset is released, one `init_start_o` pulse is issued.
- R2: A configuration write (`reg_sel_i`=0) that changes the bank-count, page-size or effective CAS-latency field produces one `init_start_o` pulse on the second rising edge after the write edge. A write that changes none of these fields produces no pulse.
- R3: A write with strobe 4'b1000 updates self-refresh (bit 31), power-down (bit 30) and refresh-in-power-down (bit 29), and never produces `init_start_o`.
- R4: The CAS-latency field (bits 11:9) is loaded only when strobes 1 and 2 are both set and bit 23 (lock) is 1 in the same write. Otherwise it keeps its value.
- R5: Only CAS latency values 2 and 3 are accepted. A write of any other value leaves `cas_lat_o` unchanged.
- R6: Byte lane 0 loads the bank-count field from bits 6:4 (0=1, 1=2, 2=4 banks) and the page-size field from bits 2:0 (0..3 = 256..2048 words). `narrow_o` stays 1 whatever is written to bit 14.
- R7: If self-refresh and power-down are both set, the block requests `sref_enter_o` and not `pdn_enter_o`. Clearing self-refresh requests `sref_exit_o`.
- R8: Power-down alone requests `pdn_enter_o`, and clearing it requests `pdn_exit_o`. Without refresh-in-power-down, the block stays in power-down while refreshes fall due.
- R9: With power-down and refresh-in-power-down both set, each due refresh produces the sequence `pdn_exit_o`, `auto_ref_o`, `pdn_enter_o`.
- R10: The refresh-rate register (`reg_sel_i`=1, bits 12:0, strobes 0 and 1) sets the refresh period in clock cycles, and a write restarts the count. In normal mode `auto_ref_o` pulses once per period. A value of 0 gives a period of 8191.
- R11: Each mode request is a single-cycle pulse. No further request is issued until `cmd_ack_i` is seen.
- R12: An initialization-triggering write that arrives while a transition is waiting for acknowledge issues `init_start_o` at once. After that initialization is acknowledged, the pending power mode is requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = configuration register, 1 = refresh-rate register |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables |
| cmd_ack_i | input | 1 | Command sequencer acknowledge |
| init_start_o | output | 1 | Start initialization pulse |
| auto_ref_o | output | 1 | Auto refresh request pulse |
| sref_enter_o | output | 1 | Enter self-refresh pulse |
| sref_exit_o | output | 1 | Leave self-refresh pulse |
| pdn_enter_o | output | 1 | Enter power-down pulse |
| pdn_exit_o | output | 1 | Leave power-down pulse |
| cas_lat_o | output | 3 | CAS latency for mode-register load |
| bank_cnt_o | output | 3 | Bank-count field |
| page_sel_o | output | 3 | Page-size field |
| narrow_o | output | 1 | 16-bit data bus select, always 1 |

## Verification
Register fields are visible on the outputs one edge after the write edge. Every request pulse, whether from a write or from an expiring refresh count, is due one further edge later. The bench therefore samples fields and pulses at the falling edge after that second rising edge, and holds `cmd_ack_i` low wherever it must show that a request waits.

The refresh period is measured in whole falling edges between consecutive `auto_ref_o` pulses, with immediate acknowledge. The first pulse after a rate write is skipped, because a refresh that was already pending may fire early. Ordered sequences such as the power-down refresh excursion are collected pulse by pulse and compared against the expected order.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int SR_BIT   = 31;
  localparam int PD_BIT   = 30;
  localparam int PDWR_BIT = 29;
  localparam int LOCK_BIT = 23;
  localparam int CL_LSB   = 9;
  localparam int BANK_LSB = 4;
  localparam int PAGE_LSB = 0;

  typedef struct packed {
    logic       sr;
    logic       pd;
    logic       pdwr;
    logic [2:0] cl;
    logic [2:0] bank;
    logic [2:0] page;
  } cfg_t;

  localparam cfg_t CFG_RST = '{sr: 1'b0, pd: 1'b0, pdwr: 1'b0,
                               cl: 3'd3, bank: 3'd2, page: 3'd0};

  typedef enum logic [3:0] {
    ST_NORM, ST_INIT_W, ST_REF_W, ST_PDN_EN_W, ST_PDN,
    ST_PDN_EX_W, ST_SR_EN_W, ST_SR, ST_SR_EX_W
  } mode_st_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_INIT, CMD_REF, CMD_PDN_EN, CMD_PDN_EX, CMD_SR_EN, CMD_SR_EX
  } cmd_e;

endpackage

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned RR_W   = 13,
  parameter int unsigned RR_RST = 1560
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [31:0]     wr_data_i,
  input  logic [3:0]      wr_be_i,
  output cfg_t            cfg_o,
  output logic [RR_W-1:0] rr_o,
  output logic            rr_wr_o,
  output logic            init_req_o
);

  cfg_t            cfg_q, cfg_d;
  logic [RR_W-1:0] rr_q, rr_d;
  logic            cfg_wr, cl_wr, geo_chg;
  logic [2:0]      cl_new;
  logic            unused_wdata;

  assign cfg_wr = wr_en_i && !wr_sel_i;
  assign cl_new = wr_data_i[CL_LSB +: 3];
  assign cl_wr  = cfg_wr && wr_be_i[1] && wr_be_i[2] && wr_data_i[LOCK_BIT]
                  && (cl_new == 3'd2 || cl_new == 3'd3);
  // narrow-mode bit is hard-wired, so bit 14 is never stored
  assign unused_wdata = ^{wr_data_i[28:24], wr_data_i[22:RR_W]};

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr && wr_be_i[3]) begin
      cfg_d.sr   = wr_data_i[SR_BIT];
      cfg_d.pd   = wr_data_i[PD_BIT];
      cfg_d.pdwr = wr_data_i[PDWR_BIT];
    end
    if (cfg_wr && wr_be_i[0]) begin
      cfg_d.bank = wr_data_i[BANK_LSB +: 3];
      cfg_d.page = wr_data_i[PAGE_LSB +: 3];
    end
    if (cl_wr) cfg_d.cl = cl_new;
  end

  assign geo_chg = (cfg_d.cl != cfg_q.cl) || (cfg_d.bank != cfg_q.bank)
                || (cfg_d.page != cfg_q.page);

  always_comb begin
    rr_d = rr_q;
    if (wr_en_i && wr_sel_i) begin
      if (wr_be_i[0]) rr_d[7:0]      = wr_data_i[7:0];
      if (wr_be_i[1]) rr_d[RR_W-1:8] = wr_data_i[RR_W-1:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= CFG_RST;
      rr_q       <= RR_W'(RR_RST);
      rr_wr_o    <= 1'b0;
      init_req_o <= 1'b1;
    end else begin
      cfg_q      <= cfg_d;
      rr_q       <= rr_d;
      rr_wr_o    <= wr_en_i && wr_sel_i && (|wr_be_i[1:0]);
      init_req_o <= geo_chg;
    end
  end

  assign cfg_o = cfg_q;
  assign rr_o  = rr_q;

  // R3
  upper_only_no_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && wr_be_i == 4'b1000) |=> !init_req_o);
  // R4
  cl_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && !(wr_be_i[1] && wr_be_i[2] && wr_data_i[LOCK_BIT])) |=> $stable(cfg_q.cl));
  // R5
  cl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.cl == 3'd2 || cfg_q.cl == 3'd3));

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned RR_W   = 13,
  parameter int unsigned RR_RST = 1560
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RR_W-1:0] rr_i,
  input  logic            reload_i,
  output logic            due_o
);

  logic [RR_W-1:0] cnt_q, eff;

  // zero rate would stall the counter, use the longest period instead
  assign eff = (rr_i == '0) ? '1 : rr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= RR_W'(RR_RST);
    else if (reload_i || cnt_q == 1) cnt_q <= eff;
    else                              cnt_q <= cnt_q - 1'b1;
  end

  assign due_o = (cnt_q == 1) && !reload_i;

  // R10
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);

endmodule

// File: rtl/sdram_mode_fsm.sv
module sdram_mode_fsm
  import sdram_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_req_i,
  input  logic due_i,
  input  logic sr_i,
  input  logic pd_i,
  input  logic pdwr_i,
  input  logic ack_i,
  output logic init_start_o,
  output logic auto_ref_o,
  output logic sref_enter_o,
  output logic sref_exit_o,
  output logic pdn_enter_o,
  output logic pdn_exit_o
);

  mode_st_e st_q, st_d;
  cmd_e     cmd;
  logic     pend_q, pend_d, ref_need;

  assign ref_need = pend_q || due_i;

  always_comb begin
    st_d = st_q;
    cmd  = CMD_NONE;
    if (init_req_i) begin
      st_d = ST_INIT_W;
      cmd  = CMD_INIT;
    end else begin
      unique case (st_q)
        ST_NORM: begin
          if (ref_need) begin
            st_d = ST_REF_W;    cmd = CMD_REF;
          end else if (sr_i) begin
            st_d = ST_SR_EN_W;  cmd = CMD_SR_EN;
          end else if (pd_i) begin
            st_d = ST_PDN_EN_W; cmd = CMD_PDN_EN;
          end
        end
        ST_INIT_W, ST_REF_W, ST_PDN_EX_W, ST_SR_EX_W:
          if (ack_i) st_d = ST_NORM;
        ST_PDN_EN_W: if (ack_i) st_d = ST_PDN;
        ST_SR_EN_W:  if (ack_i) st_d = ST_SR;
        ST_PDN: begin
          if (sr_i || !pd_i || (pdwr_i && ref_need)) begin
            st_d = ST_PDN_EX_W; cmd = CMD_PDN_EX;
          end
        end
        ST_SR: begin
          if (!sr_i) begin
            st_d = ST_SR_EX_W;  cmd = CMD_SR_EX;
          end
        end
        default: st_d = ST_NORM;
      endcase
    end
  end

  // device refreshes itself in self-refresh, so nothing stays owed
  assign pend_d = (st_q == ST_SR) ? 1'b0 : (ref_need && cmd != CMD_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_NORM;
      pend_q       <= 1'b0;
      init_start_o <= 1'b0;
      auto_ref_o   <= 1'b0;
      sref_enter_o <= 1'b0;
      sref_exit_o  <= 1'b0;
      pdn_enter_o  <= 1'b0;
      pdn_exit_o   <= 1'b0;
    end else begin
      st_q         <= st_d;
      pend_q       <= pend_d;
      init_start_o <= (cmd == CMD_INIT);
      auto_ref_o   <= (cmd == CMD_REF);
      sref_enter_o <= (cmd == CMD_SR_EN);
      sref_exit_o  <= (cmd == CMD_SR_EX);
      pdn_enter_o  <= (cmd == CMD_PDN_EN);
      pdn_exit_o   <= (cmd == CMD_PDN_EX);
    end
  end

  // R7
  sr_over_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_enter_o |-> !$past(sr_i));
  // R11
  sref_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sref_enter_o |=> !sref_enter_o);
  // R11
  pdn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_enter_o |=> !pdn_enter_o);
  // R8
  pdn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDN && pd_i && !sr_i && !pdwr_i && !init_req_i) |=> !pdn_exit_o);

endmodule

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned RR_W   = 13,
  parameter int unsigned RR_RST = 1560
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [3:0]  reg_be_i,
  input  logic        cmd_ack_i,
  output logic        init_start_o,
  output logic        auto_ref_o,
  output logic        sref_enter_o,
  output logic        sref_exit_o,
  output logic        pdn_enter_o,
  output logic        pdn_exit_o,
  output logic [2:0]  cas_lat_o,
  output logic [2:0]  bank_cnt_o,
  output logic [2:0]  page_sel_o,
  output logic        narrow_o
);

  cfg_t            cfg;
  logic [RR_W-1:0] rr;
  logic            rr_wr, init_req, due;

  sdram_cfg_regs #(.RR_W(RR_W), .RR_RST(RR_RST)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr_i), .wr_sel_i(reg_sel_i),
    .wr_data_i(reg_wdata_i), .wr_be_i(reg_be_i),
    .cfg_o(cfg), .rr_o(rr), .rr_wr_o(rr_wr), .init_req_o(init_req)
  );

  sdram_ref_timer #(.RR_W(RR_W), .RR_RST(RR_RST)) u_timer (
    .clk_i, .rst_ni, .rr_i(rr), .reload_i(rr_wr), .due_o(due)
  );

  sdram_mode_fsm u_fsm (
    .clk_i, .rst_ni,
    .init_req_i(init_req), .due_i(due),
    .sr_i(cfg.sr), .pd_i(cfg.pd), .pdwr_i(cfg.pdwr), .ack_i(cmd_ack_i),
    .init_start_o, .auto_ref_o, .sref_enter_o, .sref_exit_o,
    .pdn_enter_o, .pdn_exit_o
  );

  assign cas_lat_o  = cfg.cl;
  assign bank_cnt_o = cfg.bank;
  assign page_sel_o = cfg.page;
  assign narrow_o   = 1'b1;

endmodule

// File: tb/sdram_cfg_ctrl_bench.sv
module sdram_cfg_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, sel = 1'b0, ack = 1'b1;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        init_s, aref, sr_en, sr_ex, pd_en, pd_ex, narrow;
  logic [2:0]  cl, bank, page;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sdram_cfg_ctrl u_sdram_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_be_i(be), .cmd_ack_i(ack),
    .init_start_o(init_s), .auto_ref_o(aref), .sref_enter_o(sr_en),
    .sref_exit_o(sr_ex), .pdn_enter_o(pd_en), .pdn_exit_o(pd_ex),
    .cas_lat_o(cl), .bank_cnt_o(bank), .page_sel_o(page), .narrow_o(narrow)
  );

  typedef struct packed {
    logic        sel;
    logic [3:0]  be;
    logic [31:0] d;
    logic        init;
    logic [2:0]  cl;
    logic [2:0]  bank;
    logic [2:0]  page;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0001, 32'h0000_0021, 1'b1, 3'd3, 3'd2, 3'd1},  // R2 page change
    '{1'b0, 4'b0001, 32'h0000_0021, 1'b0, 3'd3, 3'd2, 3'd1},  // R2 same value
    '{1'b0, 4'b0010, 32'h0000_0400, 1'b0, 3'd3, 3'd2, 3'd1},  // R4 no lock
    '{1'b0, 4'b0110, 32'h0080_0400, 1'b1, 3'd2, 3'd2, 3'd1},  // R4 locked cl=2
    '{1'b0, 4'b0110, 32'h0080_0A00, 1'b0, 3'd2, 3'd2, 3'd1},  // R5 cl=5 refused
    '{1'b0, 4'b0001, 32'h0000_0001, 1'b1, 3'd2, 3'd0, 3'd1},  // R6 bank change
    '{1'b0, 4'b1111, 32'h0000_0401, 1'b0, 3'd2, 3'd0, 3'd1},  // R6 nm=0 ignored
    '{1'b0, 4'b0010, 32'h0000_0000, 1'b0, 3'd2, 3'd0, 3'd1},  // R4 byte1 only
    '{1'b0, 4'b0001, 32'h0000_0013, 1'b1, 3'd2, 3'd1, 3'd3},  // R6 bank1 page3
    '{1'b1, 4'b0011, 32'h0000_1388, 1'b0, 3'd2, 3'd1, 3'd3},  // R10 rate write
    '{1'b0, 4'b0111, 32'h0080_0613, 1'b1, 3'd3, 3'd1, 3'd3}   // R4 locked cl=3
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ends at the falling edge after the write edge
  task automatic wr_reg(input logic s, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; sel = s; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  function automatic int pulse_code();
    if (init_s) return 1;
    if (aref)   return 2;
    if (pd_en)  return 3;
    if (pd_ex)  return 4;
    if (sr_en)  return 5;
    if (sr_ex)  return 6;
    return 0;
  endfunction

  task automatic next_pulse(input int max_cyc, output int code);
    code = 0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      code = pulse_code();
      if (code != 0) break;
    end
  endtask

  task automatic ref_gap(input int max_cyc, output int gap);
    gap = 0;
    for (int i = 1; i <= max_cyc; i++) begin
      @(negedge clk);
      if (aref) begin gap = i; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int code, gap, cnt;
    int seq [6];
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pulse_code() == 0, "R1 pulses in reset", pulse_code(), 0);
    chk(cl == 3'd3 && bank == 3'd2 && page == 3'd0, "R1 reset fields",
        {cl, bank, page}, {3'd3, 3'd2, 3'd0});
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(init_s == 1'b1, "R1 init after reset", init_s, 1);
    @(negedge clk);
    chk(init_s == 1'b0, "R1 init single pulse", init_s, 0);
    repeat (3) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr_reg(VECS[v].sel, VECS[v].be, VECS[v].d);
      @(negedge clk);
      chk(init_s == VECS[v].init, $sformatf("R2 init vec%0d", v), init_s, VECS[v].init);
      chk(cl == VECS[v].cl, $sformatf("R4 R5 cl vec%0d", v), cl, VECS[v].cl);
      chk(bank == VECS[v].bank && page == VECS[v].page,
          $sformatf("R6 geometry vec%0d", v), {bank, page}, {VECS[v].bank, VECS[v].page});
      chk(narrow == 1'b1, $sformatf("R6 narrow vec%0d", v), narrow, 1);
      repeat (2) @(negedge clk);
    end
    wr_reg(1'b1, 4'b0011, 32'd8000);

    // R8 R11 power-down with held acknowledge
    ack = 1'b0;
    wr_reg(1'b0, 4'b1000, 32'h4000_0000);
    @(negedge clk);
    chk(pd_en == 1'b1, "R8 pdn_enter", pd_en, 1);
    chk(init_s == 1'b0, "R3 upper byte no init", init_s, 0);
    cnt = 0;
    repeat (4) begin @(negedge clk); if (pulse_code() != 0) cnt++; end
    chk(cnt == 0, "R11 waits for ack", cnt, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    wr_reg(1'b0, 4'b1000, 32'h0000_0000);
    @(negedge clk);
    chk(pd_ex == 1'b1, "R8 pdn_exit", pd_ex, 1);
    ack = 1'b1;
    repeat (3) @(negedge clk);

    // R7 self-refresh wins over power-down
    wr_reg(1'b0, 4'b1000, 32'hC000_0000);
    @(negedge clk);
    chk(sr_en == 1'b1 && pd_en == 1'b0, "R7 sref priority", {sr_en, pd_en}, 2);
    repeat (3) @(negedge clk);
    wr_reg(1'b0, 4'b1000, 32'h0000_0000);
    @(negedge clk);
    chk(sr_ex == 1'b1, "R7 sref_exit", sr_ex, 1);
    repeat (3) @(negedge clk);

    // R12 init aborts a pending power-down entry
    ack = 1'b0;
    wr_reg(1'b0, 4'b1000, 32'h4000_0000);
    @(negedge clk);
    wr_reg(1'b0, 4'b0001, 32'h0000_0012);
    @(negedge clk);
    chk(init_s == 1'b1, "R12 init during wait", init_s, 1);
    chk(page == 3'd2, "R6 page after abort", page, 2);
    ack = 1'b1;
    next_pulse(6, code);
    chk(code == 3, "R12 power-down requested again", code, 3);
    wr_reg(1'b0, 4'b1000, 32'h0000_0000);
    repeat (6) @(negedge clk);

    // R8 no refresh excursion without pdwr
    wr_reg(1'b1, 4'b0011, 32'd30);
    wr_reg(1'b0, 4'b1000, 32'h4000_0000);
    next_pulse(6, code);
    chk(code == 3, "R8 pdn_enter rr30", code, 3);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (pulse_code() != 0) cnt++; end
    chk(cnt == 0, "R8 stays in power-down", cnt, 0);

    // R9 refresh excursions
    wr_reg(1'b0, 4'b1000, 32'h6000_0000);
    for (int i = 0; i < 6; i++) next_pulse(60, seq[i]);
    for (int i = 0; i < 6; i++) begin
      int exp;
      exp = (i % 3 == 0) ? 4 : (i % 3 == 1) ? 2 : 3;
      chk(seq[i] == exp, $sformatf("R9 pulse %0d", i), seq[i], exp);
    end
    wr_reg(1'b0, 4'b1000, 32'h0000_0000);
    repeat (10) @(negedge clk);

    // R10 refresh period
    wr_reg(1'b1, 4'b0011, 32'd20);
    ref_gap(100, gap);
    ref_gap(100, gap);
    chk(gap == 20, "R10 period 20", gap, 20);
    ref_gap(100, gap);
    chk(gap == 20, "R10 period 20 again", gap, 20);
    wr_reg(1'b1, 4'b0011, 32'd0);
    ref_gap(9000, gap);
    ref_gap(9000, gap);
    chk(gap == 8191, "R10 zero rate", gap, 8191);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule